// File: doc/BRIEF.md
# Packet-Aware Stream Width Converter

This block moves a valid/ready data stream from one bus width to another, where the wider width is the narrower one times a power of two. Each bus carries data, one strobe bit per byte lane, a packet end flag and a user sideband field. When the input is wider, every accepted word is cut into narrower slices that leave least significant first. When the output is wider, consecutive input beats are packed into one word from the low end upwards.

A parameter selects a packet-length mode for packets whose length is not a whole number of wide words. In this mode a narrowing converter moves the end flag onto the last slice that still holds strobed bytes and drops the empty slices behind it. A widening converter sends a word early when the end flag arrives, filling the unused lanes with zero data, zero strobe and zero user bits. In this mode every input beat must have at least one strobe bit, every beat other than the packet end must be fully strobed, and set strobe bits must be contiguous from lane 0.

The user field is copied onto every slice when narrowing. When widening, the output user field is wider by the ratio and holds the user values of the packed beats side by side. The first beat's value sits in the low bits.

Top module: `stream_width_conv`

## Requirements
- R1: A synchronous reset discards any partly packed or partly sent word; in the cycle after reset out_valid is 0 and in_ready is 1, and the first word after reset contains only beats accepted after reset.
- R2: When narrowing, each accepted input word yields RATIO output beats (fewer only under R5), the slice from bits [OUT_W-1:0] first, then in rising order, each carrying the user value of its input word.
- R3: When widening, RATIO accepted input beats form one output word, the first beat in bits [IN_W-1:0] and later beats in rising slices; out_user holds the user values in the same slice order.
- R4: With UNALIGNED=0 and narrowing, each output beat's strobe is the matching strobe slice of the input, slices with all-zero strobe are still sent, and out_last is 1 only on the final slice of a word that had in_last set.
- R5: With UNALIGNED=1 and narrowing, for a word with in_last set, out_last is on the highest slice whose strobe is not all zero, and no slice above it is sent.
- R6: With UNALIGNED=0 and widening, strobes are packed like data, and out_last equals the in_last of the beat that filled the top slice.
- R7: With UNALIGNED=1 and widening, a beat with in_last set completes the word at once; lanes not filled carry zero data, zero strobe and zero user, out_last is 1, and the next beat starts a new word in the low slice.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_strb, out_last and out_user keep their values and in_ready is 0.
- R9: With out_ready held at 1 and input offered every cycle, the narrow side moves one beat per cycle with no gap, across word boundaries.
- R10: When narrowing, the first slice of a word is offered on the cycle after that word is accepted; when widening, the word is offered on the cycle after the beat that completes it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken this cycle |
| in_data | input | IN_W | Input data |
| in_strb | input | IN_W/8 | Input byte strobes, bit k for byte lane k |
| in_last | input | 1 | Input beat ends a packet |
| in_user | input | USER_W | Input sideband |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | OUT_W | Output data |
| out_strb | output | OUT_W/8 | Output byte strobes |
| out_last | output | 1 | Output beat ends a packet |
| out_user | output | UO_W | Output sideband: USER_W when narrowing, USER_W*RATIO when widening |

## Verification
A narrowing converter presents its first slice one cycle after the input handshake and a new slice every following cycle that out_ready is high. A widening converter presents a word one cycle after the completing beat is taken. The bench samples every port on the falling clock edge and stamps each input and output handshake with a cycle number. The latency and gap-free throughput checks compare those stamps directly: one cycle between input and first output, and one cycle between consecutive beats. Held-output behaviour is checked by keeping out_ready low for several falling edges and comparing the outputs on each of them.

// File: rtl/swc_pkg.sv
`timescale 1ns/1ps
package swc_pkg;

  // Conversion factor between the two bus widths, always >= 1.
  function automatic int conv_ratio(input int a_w, input int b_w);
    return (a_w > b_w) ? (a_w / b_w) : (b_w / a_w);
  endfunction

  // Width of an index that counts 0 .. n-1, at least one bit.
  function automatic int idx_bits(input int n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/swc_down.sv
`timescale 1ns/1ps
// Wide-to-narrow: holds one input word and walks its slices low first.
module swc_down #(
  parameter int IN_W      = 32,
  parameter int OUT_W     = 8,
  parameter int USER_W    = 4,
  parameter bit UNALIGNED = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [IN_W-1:0]      in_data,
  input  logic [IN_W/8-1:0]    in_strb,
  input  logic                 in_last,
  input  logic [USER_W-1:0]    in_user,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [OUT_W-1:0]     out_data,
  output logic [OUT_W/8-1:0]   out_strb,
  output logic                 out_last,
  output logic [USER_W-1:0]    out_user
);
  localparam int RATIO = swc_pkg::conv_ratio(IN_W, OUT_W);
  localparam int IDX_W = swc_pkg::idx_bits(RATIO);
  localparam int ISB   = IN_W / 8;
  localparam int OSB   = OUT_W / 8;

  logic              full_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  fin_q;
  logic [IDX_W-1:0]  fin_d;
  logic [IN_W-1:0]   data_q;
  logic [ISB-1:0]    strb_q;
  logic              last_q;
  logic [USER_W-1:0] user_q;
  logic              at_end;
  logic              take;

  // Index of the final slice to send for the word being loaded.
  always_comb begin
    fin_d = IDX_W'(RATIO - 1);
    if (UNALIGNED && in_last) begin
      fin_d = '0;
      for (int k = 0; k < RATIO; k++) begin
        if (|in_strb[k*OSB +: OSB]) fin_d = IDX_W'(k);
      end
    end
  end

  assign at_end   = (idx_q == fin_q);
  assign in_ready = !full_q || (out_ready && at_end);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      idx_q  <= '0;
      fin_q  <= '0;
    end else if (take) begin
      full_q <= 1'b1;
      idx_q  <= '0;
      fin_q  <= fin_d;
    end else if (full_q && out_ready) begin
      if (at_end) full_q <= 1'b0;
      else        idx_q  <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      data_q <= in_data;
      strb_q <= in_strb;
      last_q <= in_last;
      user_q <= in_user;
    end
  end

  assign out_valid = full_q;
  assign out_data  = data_q[idx_q*OUT_W +: OUT_W];
  assign out_strb  = strb_q[idx_q*OSB +: OSB];
  assign out_last  = last_q && at_end;
  assign out_user  = user_q;

endmodule

// File: rtl/swc_up.sv
`timescale 1ns/1ps
// Narrow-to-wide: packs beats into the output word from the low slice up.
module swc_up #(
  parameter int IN_W      = 8,
  parameter int OUT_W     = 32,
  parameter int USER_W    = 4,
  parameter bit UNALIGNED = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [IN_W-1:0]             in_data,
  input  logic [IN_W/8-1:0]           in_strb,
  input  logic                        in_last,
  input  logic [USER_W-1:0]           in_user,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [OUT_W-1:0]            out_data,
  output logic [OUT_W/8-1:0]          out_strb,
  output logic                        out_last,
  output logic [USER_W*(OUT_W/IN_W)-1:0] out_user
);
  localparam int RATIO = swc_pkg::conv_ratio(IN_W, OUT_W);
  localparam int IDX_W = swc_pkg::idx_bits(RATIO);
  localparam int ISB   = IN_W / 8;
  localparam int OSB   = OUT_W / 8;
  localparam int UO_W  = USER_W * RATIO;

  logic              ovalid_q;
  logic [IDX_W-1:0]  idx_q;
  logic [OUT_W-1:0]  data_q, nxt_data;
  logic [OSB-1:0]    strb_q, nxt_strb;
  logic [UO_W-1:0]   user_q, nxt_user;
  logic              last_q;
  logic              take;
  logic              done;
  logic              fresh;

  assign in_ready = !ovalid_q || out_ready;
  assign take     = in_valid && in_ready;
  assign fresh    = (idx_q == '0);
  assign done     = (idx_q == IDX_W'(RATIO - 1)) || (UNALIGNED && in_last);

  // A new word starts from all-zero lanes, which become the padding.
  always_comb begin
    nxt_data = fresh ? '0 : data_q;
    nxt_strb = fresh ? '0 : strb_q;
    nxt_user = fresh ? '0 : user_q;
    nxt_data[idx_q*IN_W   +: IN_W]   = in_data;
    nxt_strb[idx_q*ISB    +: ISB]    = in_strb;
    nxt_user[idx_q*USER_W +: USER_W] = in_user;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovalid_q <= 1'b0;
      idx_q    <= '0;
    end else if (take) begin
      if (done) begin
        ovalid_q <= 1'b1;
        idx_q    <= '0;
      end else begin
        ovalid_q <= 1'b0;
        idx_q    <= idx_q + 1'b1;
      end
    end else if (ovalid_q && out_ready) begin
      ovalid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      data_q <= nxt_data;
      strb_q <= nxt_strb;
      user_q <= nxt_user;
      if (done) last_q <= in_last;
    end
  end

  assign out_valid = ovalid_q;
  assign out_data  = data_q;
  assign out_strb  = strb_q;
  assign out_last  = last_q;
  assign out_user  = user_q;

endmodule

// File: rtl/stream_width_conv.sv
`timescale 1ns/1ps
module stream_width_conv #(
  parameter int IN_W      = 32,
  parameter int OUT_W     = 8,
  parameter int USER_W    = 4,
  parameter bit UNALIGNED = 1'b0,
  localparam int UO_W     = (IN_W > OUT_W) ? USER_W : USER_W * (OUT_W / IN_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [IN_W-1:0]      in_data,
  input  logic [IN_W/8-1:0]    in_strb,
  input  logic                 in_last,
  input  logic [USER_W-1:0]    in_user,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [OUT_W-1:0]     out_data,
  output logic [OUT_W/8-1:0]   out_strb,
  output logic                 out_last,
  output logic [UO_W-1:0]      out_user
);

  generate
    if (IN_W > OUT_W) begin : g_narrow
      swc_down #(
        .IN_W(IN_W), .OUT_W(OUT_W), .USER_W(USER_W), .UNALIGNED(UNALIGNED)
      ) u_down (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_strb(in_strb), .in_last(in_last), .in_user(in_user),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_strb(out_strb), .out_last(out_last), .out_user(out_user)
      );
    end else begin : g_widen
      swc_up #(
        .IN_W(IN_W), .OUT_W(OUT_W), .USER_W(USER_W), .UNALIGNED(UNALIGNED)
      ) u_up (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_strb(in_strb), .in_last(in_last), .in_user(in_user),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_strb(out_strb), .out_last(out_last), .out_user(out_user)
      );
    end
  endgenerate

endmodule

// File: rtl/swc_checker.sv
`timescale 1ns/1ps
module swc_checker #(
  parameter int IN_W      = 32,
  parameter int OUT_W     = 8,
  parameter int UO_W      = 4,
  parameter bit UNALIGNED = 1'b0
) (
  input logic               clk,
  input logic               rst,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [OUT_W-1:0]   out_data,
  input logic [OUT_W/8-1:0] out_strb,
  input logic               out_last,
  input logic [UO_W-1:0]    out_user
);

  // R1: reset empties the output.
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R8: a stalled output beat keeps every field.
  assert_hold_stalled_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_strb) && $stable(out_last) && $stable(out_user)));

  // R8: no new input is taken while the output is stalled.
  assert_no_take_stalled_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  generate
    if (UNALIGNED && (IN_W > OUT_W)) begin : g_nar_chk
      // R5: a moved packet end always sits on a slice with strobed bytes.
      assert_last_strobed_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> (out_strb != '0));
    end
    if (UNALIGNED && (IN_W < OUT_W)) begin : g_wid_chk
      // R7: padding never reaches the low lane of a sent word.
      assert_low_lane_real_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_strb[0]);
    end
  endgenerate

endmodule

bind stream_width_conv swc_checker #(
  .IN_W(IN_W), .OUT_W(OUT_W), .UO_W(UO_W), .UNALIGNED(UNALIGNED)
) u_swc_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_strb(out_strb),
  .out_last(out_last), .out_user(out_user)
);

// File: tb/sim_stream_width_conv.sv
`timescale 1ns/1ps
module sim_stream_width_conv;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;

  // Narrowing pair (32 -> 8): u0 basic, u1 unaligned mode.
  logic [31:0] dn_data = '0;
  logic [3:0]  dn_strb = '0;
  logic        dn_last = 1'b0;
  logic [3:0]  dn_user = '0;
  logic        dn_v0 = 1'b0, dn_v1 = 1'b0, dn_ordy = 1'b1;
  logic        r0, r1, ov0, ov1, ol0, ol1;
  logic [7:0]  od0, od1;
  logic [0:0]  os0, os1;
  logic [3:0]  ou0, ou1;

  // Widening pair (8 -> 32): u2 basic, u3 unaligned mode.
  logic [7:0]  up_data = '0;
  logic [0:0]  up_strb = 1'b1;
  logic        up_last = 1'b0;
  logic [3:0]  up_user = '0;
  logic        up_v2 = 1'b0, up_v3 = 1'b0, up_ordy = 1'b1;
  logic        r2, r3, ov2, ov3, ol2, ol3;
  logic [31:0] od2, od3;
  logic [3:0]  os2, os3;
  logic [15:0] ou2, ou3;

  stream_width_conv #(.IN_W(32), .OUT_W(8), .USER_W(4), .UNALIGNED(1'b0)) u0 (
    .clk(clk), .rst(rst), .in_valid(dn_v0), .in_ready(r0), .in_data(dn_data),
    .in_strb(dn_strb), .in_last(dn_last), .in_user(dn_user), .out_valid(ov0),
    .out_ready(dn_ordy), .out_data(od0), .out_strb(os0), .out_last(ol0), .out_user(ou0));
  stream_width_conv #(.IN_W(32), .OUT_W(8), .USER_W(4), .UNALIGNED(1'b1)) u1 (
    .clk(clk), .rst(rst), .in_valid(dn_v1), .in_ready(r1), .in_data(dn_data),
    .in_strb(dn_strb), .in_last(dn_last), .in_user(dn_user), .out_valid(ov1),
    .out_ready(dn_ordy), .out_data(od1), .out_strb(os1), .out_last(ol1), .out_user(ou1));
  stream_width_conv #(.IN_W(8), .OUT_W(32), .USER_W(4), .UNALIGNED(1'b0)) u2 (
    .clk(clk), .rst(rst), .in_valid(up_v2), .in_ready(r2), .in_data(up_data),
    .in_strb(up_strb), .in_last(up_last), .in_user(up_user), .out_valid(ov2),
    .out_ready(up_ordy), .out_data(od2), .out_strb(os2), .out_last(ol2), .out_user(ou2));
  stream_width_conv #(.IN_W(8), .OUT_W(32), .USER_W(4), .UNALIGNED(1'b1)) u3 (
    .clk(clk), .rst(rst), .in_valid(up_v3), .in_ready(r3), .in_data(up_data),
    .in_strb(up_strb), .in_last(up_last), .in_user(up_user), .out_valid(ov3),
    .out_ready(up_ordy), .out_data(od3), .out_strb(os3), .out_last(ol3), .out_user(ou3));

  function automatic logic [63:0] pk(input logic last, input logic [15:0] user,
                                     input logic [3:0] strb, input logic [31:0] data);
    return {11'b0, last, user, strb, data};
  endfunction

  // Output monitors: record each beat that handshakes at the next rising edge.
  logic [63:0] mrec [4][64];
  int          mst  [4][64];
  int          mn   [4];
  initial for (int i = 0; i < 4; i++) mn[i] = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (ov0 && dn_ordy && mn[0] < 64) begin
        mrec[0][mn[0]] = pk(ol0, {12'b0, ou0}, {3'b0, os0}, {24'b0, od0}); mst[0][mn[0]] = cyc; mn[0]++;
      end
      if (ov1 && dn_ordy && mn[1] < 64) begin
        mrec[1][mn[1]] = pk(ol1, {12'b0, ou1}, {3'b0, os1}, {24'b0, od1}); mst[1][mn[1]] = cyc; mn[1]++;
      end
      if (ov2 && up_ordy && mn[2] < 64) begin
        mrec[2][mn[2]] = pk(ol2, ou2, os2, od2); mst[2][mn[2]] = cyc; mn[2]++;
      end
      if (ov3 && up_ordy && mn[3] < 64) begin
        mrec[3][mn[3]] = pk(ol3, ou3, os3, od3); mst[3][mn[3]] = cyc; mn[3]++;
      end
    end
  end

  int in_st [64];
  int n_in = 0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drivers are entered on a falling edge and leave on the falling edge
  // after the handshake, with valid still high (for back-to-back bursts).
  task automatic send_dn(input int which, input logic [31:0] d, input logic [3:0] s,
                         input logic l, input logic [3:0] u);
    dn_data = d; dn_strb = s; dn_last = l; dn_user = u;
    dn_v0 = (which == 0); dn_v1 = (which == 1);
    while (!((which == 0) ? r0 : r1)) @(negedge clk);
    in_st[n_in] = cyc; n_in++;
    @(negedge clk);
  endtask

  task automatic send_up(input int which, input logic [7:0] d, input logic l,
                         input logic [3:0] u);
    up_data = d; up_strb = 1'b1; up_last = l; up_user = u;
    up_v2 = (which == 2); up_v3 = (which == 3);
    while (!((which == 2) ? r2 : r3)) @(negedge clk);
    in_st[n_in] = cyc; n_in++;
    @(negedge clk);
  endtask

  task automatic idle();
    dn_v0 = 1'b0; dn_v1 = 1'b0; up_v2 = 1'b0; up_v3 = 1'b0;
  endtask

  // Narrowing stimulus: {last, user, strb, data}.
  localparam logic [40:0] DN_VEC [4] = '{
    {1'b0, 4'h1, 4'hF, 32'h44332211},
    {1'b1, 4'h2, 4'h3, 32'h88776655},
    {1'b0, 4'h3, 4'hF, 32'hDDCCBBAA},
    {1'b1, 4'h4, 4'h1, 32'h000000EE}
  };

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int base, k, fin, e;
    logic [40:0] v;
    repeat (3) @(negedge clk);
    // R1: state after reset.
    chk("R1", "out_valid all", {60'b0, ov0, ov1, ov2, ov3}, 64'h0);
    chk("R1", "in_ready all",  {60'b0, r0, r1, r2, r3},     64'hF);
    rst = 1'b0;
    @(negedge clk);

    // Table walk through both narrowing modes.
    for (int m = 0; m < 2; m++) begin
      base = mn[m]; n_in = 0; dn_ordy = 1'b1;
      for (int i = 0; i < 4; i++) begin
        v = DN_VEC[i];
        send_dn(m, v[31:0], v[35:32], v[40], v[39:36]);
      end
      idle();
      repeat (8) @(negedge clk);
      k = base;
      for (int i = 0; i < 4; i++) begin
        v = DN_VEC[i];
        fin = 3;
        if (m == 1 && v[40]) for (int j = 0; j < 4; j++) if (v[32+j]) fin = j;
        for (int j = 0; j <= fin; j++) begin
          chk(m == 0 ? "R2 R4" : "R2 R5", "narrow beat", mrec[m][k],
              pk(v[40] && (j == fin), {12'b0, v[39:36]}, {3'b0, v[32+j]},
                 {24'b0, v[8*j +: 8]}));
          k++;
        end
      end
      chk(m == 0 ? "R4" : "R5", "beat count", 64'(mn[m] - base), 64'(k - base));
      for (int j = base + 1; j < mn[m]; j++)
        if (mst[m][j] != mst[m][j-1] + 1)
          chk("R9", "narrow gap", 64'(mst[m][j] - mst[m][j-1]), 64'd1);
      n_chk++;
      chk("R10", "narrow first slice", 64'(mst[m][base]), 64'(in_st[0] + 1));
    end

    // R8: stall on a narrowing output.
    dn_ordy = 1'b0; base = mn[0]; n_in = 0;
    send_dn(0, 32'hA1B2C3D4, 4'hF, 1'b1, 4'h9);
    idle();
    for (int i = 0; i < 3; i++) begin
      chk("R8", "stalled beat", {51'b0, ov0, r0, ol0, ou0, od0}, {51'b0, 1'b1, 1'b0, 1'b0, 4'h9, 8'hD4});
      @(negedge clk);
    end
    dn_ordy = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8", "after stall count", 64'(mn[0] - base), 64'd4);
    chk("R8 R2", "after stall last", mrec[0][base+3], pk(1'b1, 16'h9, 4'h1, 32'hA1));

    // Widening, basic mode.
    base = mn[2]; n_in = 0; up_ordy = 1'b1;
    send_up(2, 8'h11, 1'b0, 4'h1); send_up(2, 8'h22, 1'b0, 4'h2);
    send_up(2, 8'h33, 1'b0, 4'h3); send_up(2, 8'h44, 1'b1, 4'h4);
    send_up(2, 8'h55, 1'b0, 4'h5); send_up(2, 8'h66, 1'b1, 4'h6);
    send_up(2, 8'h77, 1'b0, 4'h7); send_up(2, 8'h88, 1'b0, 4'h8);
    idle();
    repeat (4) @(negedge clk);
    chk("R3", "widen count", 64'(mn[2] - base), 64'd2);
    chk("R3 R6", "widen word0", mrec[2][base],   pk(1'b1, 16'h4321, 4'hF, 32'h44332211));
    chk("R6", "widen word1",    mrec[2][base+1], pk(1'b0, 16'h8765, 4'hF, 32'h88776655));
    chk("R9", "widen input span", 64'(in_st[7] - in_st[0]), 64'd7);
    chk("R10", "widen latency", 64'(mst[2][base]), 64'(in_st[3] + 1));

    // Widening, unaligned mode with early packet ends.
    base = mn[3]; n_in = 0;
    send_up(3, 8'h11, 1'b0, 4'h1); send_up(3, 8'h22, 1'b0, 4'h2);
    send_up(3, 8'h33, 1'b0, 4'h3); send_up(3, 8'h44, 1'b1, 4'h4);
    send_up(3, 8'h55, 1'b0, 4'h5); send_up(3, 8'h66, 1'b1, 4'h6);
    send_up(3, 8'hAA, 1'b1, 4'hA);
    idle();
    repeat (4) @(negedge clk);
    chk("R7", "pad count", 64'(mn[3] - base), 64'd3);
    chk("R7", "pad word0", mrec[3][base],   pk(1'b1, 16'h4321, 4'hF, 32'h44332211));
    chk("R7", "pad word1", mrec[3][base+1], pk(1'b1, 16'h0065, 4'h3, 32'h00006655));
    chk("R7", "pad word2", mrec[3][base+2], pk(1'b1, 16'h000A, 4'h1, 32'h000000AA));
    chk("R10", "pad latency", 64'(mst[3][base+2]), 64'(in_st[6] + 1));
    chk("R9", "pad input span", 64'(in_st[6] - in_st[0]), 64'd6);

    // R1: reset drops a partial wide word and a pending narrow word.
    base = mn[2]; n_in = 0;
    send_up(2, 8'h99, 1'b0, 4'hC);
    dn_ordy = 1'b0;
    send_dn(0, 32'h01020304, 4'hF, 1'b0, 4'h5);
    idle();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1", "after reset valid", {62'b0, ov0, ov2}, 64'h0);
    chk("R1", "after reset ready", {62'b0, r0, r2}, 64'h3);
    e = mn[0];
    dn_ordy = 1'b1;
    send_up(2, 8'hB1, 1'b0, 4'h1); send_up(2, 8'hB2, 1'b0, 4'h2);
    send_up(2, 8'hB3, 1'b0, 4'h3); send_up(2, 8'hB4, 1'b1, 4'h4);
    idle();
    repeat (4) @(negedge clk);
    chk("R1", "narrow after reset", 64'(mn[0] - e), 64'd0);
    chk("R1", "wide after reset count", 64'(mn[2] - base), 64'd1);
    chk("R1", "wide after reset word", mrec[2][base], pk(1'b1, 16'h4321, 4'hF, 32'hB4B3B2B1));

    summary();
    $finish;
  end

endmodule